// File: doc/BRIEF.md
# Interleaved multiphase PWM generator

This block is the digital pulse-width engine of a buck converter with two, three or four power stages. Every active stage owns a free-running sawtooth counter, and the counters are staggered so that the stages switch at evenly spaced instants within one switching period. Each stage turns its pulse on while its counter is below a compare level. That level starts from a shared duty command. A current-balance term, which is that stage's sampled current minus the mean of all active stages, is subtracted from it. The result is then saturated, capped by a maximum-duty limit and clamped by a soft-start level.

The stage count is found at power-up. While `por_i` is high, the block reads the levels of the third and fourth output pins. A pin pulled high marks its stage as absent. When `por_i` falls, the stage mask, the period and the phase spacing are frozen, and the counters start. Each output pin has three states, signalled by a data bit and an enable bit. A single-cycle strobe per stage marks the last cycle of its off interval, which is where the external current sense should take its sample.

Top module: `mpwm_gen`

## Requirements
- R1: Stages 1 and 2 are always in use. Stage 3 is in use iff `opt_hi_i[0]`=0. Stage 4 is in use iff both `opt_hi_i[0]`=0 and `opt_hi_i[1]`=0. `pwm_en_o[k]`=1 means pin k is driven; 0 means high-impedance, and then `pwm_o[k]` and `smp_o[k]` are 0. After reset and before the first `por_i` pulse, every enable is 0. Afterwards the enables equal the stage mask, so the only mask values are 4'b0011, 4'b0111 and 4'b1111.
- R2: A cycle in which `por_i` is high clears every enable from the next cycle on. The mask, the period P (`period_i`) and the stage count N are taken from the last cycle in which `por_i` was high. Raising `por_i` again redoes the detection.
- R3: Let t be the number of cycles since the first cycle with enables set (t=0 in that cycle). The counter of stage k (k=0..3) is (t - k*floor(P/N)) mod P. Changes of `period_i` after `por_i` falls have no effect.
- R4: While its stage is enabled and the soft-start level is at least the valley, `pwm_o[k]`=1 iff counter_k < L_k. L_k is the smallest of: the saturated duty, the maximum duty M, and the soft-start room.
- R5: The correction for stage k is cur_k - floor(S/N), where S is the sum of the currents of the stages in use. The saturated duty is `duty_i` minus that correction. Currents of unused stages have no effect.
- R6: M = floor(P/2) + floor(P/8) + floor(P/32), which is about 66 % of P.
- R7: The soft-start room is `ss_i` - VALLEY (default 64) when `ss_i` >= VALLEY. When `ss_i` < VALLEY, every `pwm_o` is 0 while the enables stay as they are.
- R8: `smp_o[k]`=1 exactly in the cycles where stage k is enabled and its counter equals P-1; `pwm_o[k]` is 0 in those cycles.
- R9: A duty minus correction below 0 gives a level of 0, so the stage produces no pulse. A result above P is limited to P before the cap to M is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on detection window, active high |
| opt_hi_i | input | 2 | Levels read on the pins of stages 3 and 4 (1 = tied high) |
| period_i | input | 10 | Switching period in clock cycles (at least 8) |
| duty_i | input | 10 | Shared duty command in clock cycles |
| cur_i | input | 40 | Sampled stage currents, 10 bits per stage, stage 0 in the low bits |
| ss_i | input | 11 | Soft-start level |
| pwm_o | output | 4 | Pin data per stage |
| pwm_en_o | output | 4 | Pin drive enable per stage (0 = high-impedance) |
| smp_o | output | 4 | Current-sample strobe per stage |

## Verification
On every cycle, the assertions check several properties. A pin that is not driven is quiet, and the enable mask has one of its three legal shapes. The mask is cleared after `por_i` and holds steady between detection windows. No strobe coincides with a high pin, and no pulse appears while soft-start sits below the valley. The phase stagger, the current-balance arithmetic, the saturation, the duty cap and the soft-start room depend on numeric levels over whole periods, so only the bench's reference model shows them. That model predicts every pin and strobe for several stage counts, odd periods, skewed currents and ramped soft-start levels.

// File: rtl/mpwm_pkg.sv
`timescale 1ns/1ps
package mpwm_pkg;
  localparam int NUM_PH = 4;
  typedef logic [2:0] nph_t;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mpwm_cfg.sv
`timescale 1ns/1ps
module mpwm_cfg
  import mpwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic [1:0]        opt_hi_i,
  input  logic [CNT_W-1:0]  period_i,
  output logic              run_o,
  output logic [NUM_PH-1:0] used_o,
  output nph_t              nph_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  off_o
);
  logic              cfg_q, run_q;
  logic [NUM_PH-1:0] used_q, det_used;
  nph_t              nph_q, det_n;
  logic [CNT_W-1:0]  per_q, off_q, det_off;

  // a high pin marks an absent stage; stage 4 needs stage 3
  assign det_used = {~opt_hi_i[0] & ~opt_hi_i[1], ~opt_hi_i[0], 2'b11};
  assign det_n    = 3'd2 + {2'b00, det_used[2]} + {2'b00, det_used[3]};

  always_comb begin
    unique case (det_n)
      3'd4:    det_off = period_i >> 2;
      3'd3:    det_off = period_i / CNT_W'(3);
      default: det_off = period_i >> 1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= 1'b0;
      run_q  <= 1'b0;
      used_q <= '0;
      nph_q  <= 3'd2;
      per_q  <= '0;
      off_q  <= '0;
    end else if (por_i) begin
      cfg_q  <= 1'b1;
      run_q  <= 1'b0;
      used_q <= det_used;
      nph_q  <= det_n;
      per_q  <= period_i;
      off_q  <= det_off;
    end else if (cfg_q) begin
      run_q  <= 1'b1;
    end
  end

  assign run_o  = run_q;
  assign used_o = used_q;
  assign nph_o  = nph_q;
  assign per_o  = per_q;
  assign off_o  = off_q;
endmodule

// File: rtl/mpwm_bal.sv
`timescale 1ns/1ps
module mpwm_bal
  import mpwm_pkg::*;
#(
  parameter int CUR_W  = 10,
  parameter int CORR_W = CUR_W + 3
) (
  input  logic [NUM_PH*CUR_W-1:0]  cur_i,
  input  logic [NUM_PH-1:0]        used_i,
  input  nph_t                     nph_i,
  output logic [NUM_PH*CORR_W-1:0] corr_o
);
  localparam int SUM_W = CUR_W + 2;

  logic [SUM_W-1:0] sum, avg;

  always_comb begin
    sum = '0;
    for (int k = 0; k < NUM_PH; k++) begin
      if (used_i[k]) sum = sum + SUM_W'(cur_i[k*CUR_W +: CUR_W]);
    end
  end

  always_comb begin
    unique case (nph_i)
      3'd4:    avg = sum >> 2;
      3'd3:    avg = sum / SUM_W'(3);
      default: avg = sum >> 1;
    endcase
  end

  for (genvar k = 0; k < NUM_PH; k++) begin : g_corr
    logic signed [CORR_W-1:0] cur_s, avg_s;
    assign cur_s = $signed({{(CORR_W-CUR_W){1'b0}}, cur_i[k*CUR_W +: CUR_W]});
    assign avg_s = $signed({{(CORR_W-SUM_W){1'b0}}, avg});
    assign corr_o[k*CORR_W +: CORR_W] = cur_s - avg_s;
  end
endmodule

// File: rtl/mpwm_ch.sv
`timescale 1ns/1ps
module mpwm_ch
  import mpwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int CORR_W = 13,
  parameter int SS_W   = 11,
  parameter int VALLEY = 64,
  parameter int IDX    = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  input  logic                     used_i,
  input  logic [CNT_W-1:0]         per_i,
  input  logic [CNT_W-1:0]         off_i,
  input  logic [CNT_W-1:0]         max_on_i,
  input  logic [CNT_W-1:0]         duty_i,
  input  logic signed [CORR_W-1:0] corr_i,
  input  logic [SS_W-1:0]          ss_i,
  output logic                     pwm_o,
  output logic                     en_o,
  output logic                     smp_o
);
  localparam int RAW_W = imax(CNT_W, CORR_W) + 1;
  localparam int LW    = imax(CNT_W, SS_W) + 1;

  logic [CNT_W-1:0]        ctr_q, lag, init_val, last;
  logic signed [RAW_W-1:0] raw, per_s;
  logic [CNT_W-1:0]        lvl_sat, lvl_cap;
  logic [SS_W-1:0]         room;
  logic [LW-1:0]           lvl;
  logic                    ss_ok, active;

  assign lag      = off_i * CNT_W'(IDX);
  assign init_val = (lag == '0) ? '0 : per_i - lag;
  assign last     = per_i - CNT_W'(1);
  assign active   = run_i & used_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ctr_q <= '0;
    else if (!run_i)         ctr_q <= init_val;
    else if (ctr_q == last)  ctr_q <= '0;
    else                     ctr_q <= ctr_q + CNT_W'(1);
  end

  // duty minus balance term, saturated to [0, period]
  assign raw   = $signed({{(RAW_W-CNT_W){1'b0}}, duty_i})
               - $signed({{(RAW_W-CORR_W){corr_i[CORR_W-1]}}, corr_i});
  assign per_s = $signed({{(RAW_W-CNT_W){1'b0}}, per_i});

  always_comb begin
    if (raw < 0)          lvl_sat = '0;
    else if (raw > per_s) lvl_sat = per_i;
    else                  lvl_sat = raw[CNT_W-1:0];
  end

  assign lvl_cap = (lvl_sat > max_on_i) ? max_on_i : lvl_sat;
  assign ss_ok   = ss_i >= SS_W'(VALLEY);
  assign room    = ss_ok ? ss_i - SS_W'(VALLEY) : '0;

  always_comb begin
    if (LW'(room) < LW'(lvl_cap)) lvl = LW'(room);
    else                          lvl = LW'(lvl_cap);
  end

  assign pwm_o = active & ss_ok & (LW'(ctr_q) < lvl);
  assign en_o  = active;
  assign smp_o = active & (ctr_q == last);
endmodule

// File: rtl/mpwm_gen.sv
`timescale 1ns/1ps
module mpwm_gen
  import mpwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int CUR_W  = 10,
  parameter int SS_W   = 11,
  parameter int VALLEY = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    por_i,
  input  logic [1:0]              opt_hi_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [CNT_W-1:0]        duty_i,
  input  logic [NUM_PH*CUR_W-1:0] cur_i,
  input  logic [SS_W-1:0]         ss_i,
  output logic [NUM_PH-1:0]       pwm_o,
  output logic [NUM_PH-1:0]       pwm_en_o,
  output logic [NUM_PH-1:0]       smp_o
);
  localparam int CORR_W = CUR_W + 3;

  logic                     run;
  logic [NUM_PH-1:0]        used;
  nph_t                     nph;
  logic [CNT_W-1:0]         per, off, max_on;
  logic [NUM_PH*CORR_W-1:0] corr;

  mpwm_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_i    (por_i),
    .opt_hi_i (opt_hi_i),
    .period_i (period_i),
    .run_o    (run),
    .used_o   (used),
    .nph_o    (nph),
    .per_o    (per),
    .off_o    (off)
  );

  mpwm_bal #(.CUR_W(CUR_W), .CORR_W(CORR_W)) u_bal (
    .cur_i  (cur_i),
    .used_i (used),
    .nph_i  (nph),
    .corr_o (corr)
  );

  // ~66 % cap keeps an off interval in every period
  assign max_on = (per >> 1) + (per >> 3) + (per >> 5);

  for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
    mpwm_ch #(
      .CNT_W  (CNT_W),
      .CORR_W (CORR_W),
      .SS_W   (SS_W),
      .VALLEY (VALLEY),
      .IDX    (k)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run),
      .used_i   (used[k]),
      .per_i    (per),
      .off_i    (off),
      .max_on_i (max_on),
      .duty_i   (duty_i),
      .corr_i   ($signed(corr[k*CORR_W +: CORR_W])),
      .ss_i     (ss_i),
      .pwm_o    (pwm_o[k]),
      .en_o     (pwm_en_o[k]),
      .smp_o    (smp_o[k])
    );
  end
endmodule

// File: rtl/mpwm_gen_chk.sv
`timescale 1ns/1ps
module mpwm_gen_chk #(
  parameter int SS_W   = 11,
  parameter int VALLEY = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            por_i,
  input logic [SS_W-1:0] ss_i,
  input logic [3:0]      pwm_o,
  input logic [3:0]      pwm_en_o,
  input logic [3:0]      smp_o
);
  AST_HIZ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwm_o | smp_o) & ~pwm_en_o) == 4'b0000); // R1

  AST_MASK_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_en_o == 4'b0000 || pwm_en_o == 4'b0011 ||
    pwm_en_o == 4'b0111 || pwm_en_o == 4'b1111); // R1

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(por_i) && $past(pwm_en_o) != 4'b0000) |-> $stable(pwm_en_o)); // R2

  AST_POR_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> pwm_en_o == 4'b0000); // R2

  AST_SS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_i < SS_W'(VALLEY)) |-> pwm_o == 4'b0000); // R7

  AST_SMP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_o & pwm_o) == 4'b0000); // R8

  AST_SMP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o[0] |=> !smp_o[0]); // R8
endmodule

bind mpwm_gen mpwm_gen_chk #(.SS_W(SS_W), .VALLEY(VALLEY)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .por_i    (por_i),
  .ss_i     (ss_i),
  .pwm_o    (pwm_o),
  .pwm_en_o (pwm_en_o),
  .smp_o    (smp_o)
);

// File: tb/mpwm_gen_tb.sv
`timescale 1ns/1ps
module mpwm_gen_tb_top;
  localparam int VALLEY = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por = 1'b0;
  logic [1:0]  opt_hi = 2'b00;
  logic [9:0]  period = 10'd200;
  logic [9:0]  duty = 10'd0;
  logic [39:0] cur = '0;
  logic [10:0] ss = 11'd2000;
  logic [3:0]  pwm, pwm_en, smp;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  bit     m_cfg, m_run;
  bit     m_used [4];
  int     m_n, m_p, m_off, m_t;

  always #5 clk = ~clk;

  mpwm_gen dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .por_i    (por),
    .opt_hi_i (opt_hi),
    .period_i (period),
    .duty_i   (duty),
    .cur_i    (cur),
    .ss_i     (ss),
    .pwm_o    (pwm),
    .pwm_en_o (pwm_en),
    .smp_o    (smp)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_run = 0; m_t = 0; m_n = 2; m_p = 0; m_off = 0;
      foreach (m_used[k]) m_used[k] = 0;
    end else if (por) begin
      m_cfg = 1; m_run = 0;
      m_used[0] = 1; m_used[1] = 1;
      m_used[2] = !opt_hi[0];
      m_used[3] = !opt_hi[0] && !opt_hi[1];
      m_n = 2 + int'(m_used[2]) + int'(m_used[3]);
      m_p = int'(period);
      m_off = m_p / m_n;
    end else if (m_cfg) begin
      if (!m_run) begin m_run = 1; m_t = 0; end
      else m_t++;
    end
  end

  function automatic int cur_of(int k);
    return int'(cur[k*10 +: 10]);
  endfunction

  function automatic int level_of(int k);
    int sum = 0, avg, raw, lvl, mx, room;
    for (int j = 0; j < 4; j++) if (m_used[j]) sum += cur_of(j);
    avg = sum / m_n;
    raw = int'(duty) - (cur_of(k) - avg);
    lvl = (raw < 0) ? 0 : (raw > m_p) ? m_p : raw;
    mx = m_p / 2 + m_p / 8 + m_p / 32;
    if (lvl > mx) lvl = mx;
    room = (int'(ss) >= VALLEY) ? int'(ss) - VALLEY : 0;
    if (lvl > room) lvl = room;
    return lvl;
  endfunction

  task automatic chk(string req, string what, int k, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s ch%0d act=%0b exp=%0b time=%0t", req, what, k, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int k = 0; k < 4; k++) begin
        bit en, ep, es;
        int c;
        en = rst_n && m_run && m_used[k];
        ep = 0; es = 0;
        if (en) begin
          c = ((m_t - k * m_off) % m_p + m_p) % m_p;
          ep = (int'(ss) >= VALLEY) && (c < level_of(k));
          es = (c == m_p - 1);
        end
        chk(rst_n ? tag : "R1", "en", k, pwm_en[k], en);
        chk(rst_n ? tag : "R1", "pwm", k, pwm[k], ep);
        chk(rst_n ? tag : "R8", "smp", k, smp[k], es);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_cur(int a, int b, int c, int d);
    cur = {10'(d), 10'(c), 10'(b), 10'(a)};
  endtask

  task automatic detect(logic [1:0] pins, int p, int cycles);
    tag = "R2";
    opt_hi = pins; period = 10'(p); por = 1'b1;
    step(cycles);
    por = 1'b0;
  endtask

  initial begin
    set_cur(100, 100, 100, 100);
    duty = 10'd60;
    step(4);
    rst_n = 1'b1;
    tag = "R1"; step(10);                       // R1 idle before detection

    detect(2'b00, 200, 4);
    tag = "R3"; step(400);                      // R3 four stages, spacing 50
    period = 10'd90; step(200);                 // R3 late period change ignored
    tag = "R8"; step(200);                      // R8 strobes at P-1
    tag = "R5"; set_cur(150, 100, 80, 70); step(300);
    tag = "R6"; duty = 10'd400; step(250);      // R6 cap M=131
    tag = "R9"; duty = 10'd1000; step(200);     // R9 above P
    duty = 10'd10; set_cur(160, 100, 80, 60); step(250); // R9 below zero
    tag = "R7"; duty = 10'd120; set_cur(90, 90, 90, 90);
    ss = 11'd30; step(150);                     // R7 below valley
    ss = 11'd100; step(200);                    // R7 room 36
    for (int i = 0; i < 300; i++) begin ss = 11'(i); step(1); end
    ss = 11'd2000;

    detect(2'b10, 300, 3);                      // R1 three stages
    tag = "R1"; set_cur(120, 80, 100, 1023); duty = 10'd150; step(900);
    detect(2'b01, 150, 2);                      // R1 two stages
    tag = "R1"; set_cur(70, 110, 999, 5); duty = 10'd80; step(600);
    detect(2'b11, 100, 1);
    tag = "R4"; set_cur(40, 60, 0, 0); step(300);
    detect(2'b00, 97, 2);                       // R4 odd period
    tag = "R4"; set_cur(50, 52, 47, 55); duty = 10'd33; step(500);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule